// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block keeps a short first-in first-out store of instruction bytes between a 16-bit memory bus and an execution unit. Whenever the store has room, it requests the next aligned word (or a single byte when its fetch pointer is odd) from the bus. Fetching therefore runs ahead while earlier instructions execute. The execution unit pulls one byte per cycle from the front of the store and never waits on memory directly, except when the store is empty.

On a control transfer the execution unit raises a redirect with a target address. The store is emptied, any word that the bus returns in that same cycle is dropped, and fetching restarts at the target. A registered 2-bit status code tells outside observers what the execution side did on the previous clock edge: nothing, took the opening byte of an instruction, took a further byte of the same instruction, or emptied the store.

Top module: `ibyte_prefetch_queue`

## Requirements
- R1: After reset the store is empty, `fetch_addr` equals the `RESET_ADDR` parameter (default 0x0100), `q_status` is 00, and a read request gives no byte until a fetch completes.
- R2: Bytes leave in the order they were fetched. For a word fetch, `fetch_data[7:0]` (the byte at the even address) comes out before `fetch_data[15:8]`.
- R3: The store never holds more than `DEPTH` (six) bytes. A word request (`fetch_req` high with `fetch_single` low) is raised only while at least two slots are free, and `fetch_req` stays low while the store is full.
- R4: When the fetch pointer is odd, the block requests a single byte (`fetch_single` high). It takes that byte from `fetch_data[15:8]` and advances the pointer by one, so the next request is word aligned.
- R5: A redirect in a cycle empties the store, drops `fetch_req` in that cycle, and ignores any `fetch_ack` in that cycle. From the next cycle, `fetch_addr` equals `redirect_addr`.
- R6: A read request while the store is empty and no fetch completes in that cycle returns `rd_valid` low, and nothing is consumed.
- R7: A read request on an empty store in the cycle a fetch completes returns the first incoming byte in that same cycle. The remaining byte of the word is kept as the next byte out.
- R8: `q_status` is 00 in the cycle after an edge at which no byte was taken and no redirect occurred.
- R9: `q_status` is 01 in the cycle after an edge at which a byte was taken with `rd_first` high.
- R10: `q_status` is 11 in the cycle after an edge at which a byte was taken with `rd_first` low.
- R11: `q_status` is 10 in the cycle after an edge at which a redirect occurred. A redirect takes precedence over a read request in the same cycle.
- R12: Each completed fetch advances `fetch_addr` by the number of bytes fetched. The pointer wraps modulo 2^16, so 0xFFFE is followed by 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_req | output | 1 | Bus request for the word or byte at `fetch_addr` |
| fetch_addr | output | 16 | Byte address of the current fetch pointer |
| fetch_single | output | 1 | High when only the upper-lane byte is wanted (odd pointer) |
| fetch_ack | input | 1 | Bus completion; `fetch_data` is valid while this and `fetch_req` are high |
| fetch_data | input | 16 | Returned word, even-address byte in bits 7:0 |
| rd_req | input | 1 | Execution unit asks for one byte |
| rd_first | input | 1 | The requested byte opens a new instruction |
| rd_valid | output | 1 | A byte is delivered this cycle |
| rd_byte | output | 8 | Delivered byte |
| redirect | input | 1 | Control transfer: empty the store and restart fetching |
| redirect_addr | input | 16 | New fetch address used on redirect |
| q_status | output | 2 | Queue operation from the last edge: 00 none, 01 first byte, 10 emptied, 11 later byte |

## Verification
The embedded properties check on every cycle that the fill level stays within six and a completed fetch never exceeds the free space. They also check that the pointer steps by exactly the fetched byte count, that a redirect loads the target and empties the store by the next cycle, and that the status code follows each byte taken and each redirect. Only the bench scenarios can show byte values and their order, upper-lane selection for odd pointers, same-cycle forwarding into an empty store, stalling on empty, pointer wrap at the top of the address space, and clearing of a partly filled store by reset.

// File: rtl/pfq_pkg.sv
// Shared definitions for the instruction byte prefetch queue.
// Assumes: 2-bit status encoding is observed by logic outside the block.
package pfq_pkg;

    // Queue operation reported for the previous clock edge.
    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

endpackage

// File: rtl/pfq_ring.sv
// Byte ring buffer holding prefetched instruction bytes.
// Accepts zero, one or two bytes per cycle and releases at most one.
// A byte popped while the ring is empty is taken straight from the
// incoming bytes. Assumes the producer never offers more bytes than
// there are free slots, and DEPTH >= 3.
module pfq_ring #(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [1:0]        push_n,
    input  logic [BYTE_W-1:0] push_lo,
    input  logic [BYTE_W-1:0] push_hi,
    input  logic              pop_req,
    output logic              pop_ok,
    output logic [BYTE_W-1:0] pop_byte,
    output logic [CNT_W-1:0]  level
);

    logic [BYTE_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic [IDX_W-1:0]  tail_p1;
    logic [IDX_W-1:0]  tail_p2;
    logic              has_old;
    logic              bypass;
    logic              pop_old;
    logic [1:0]        st_n;
    logic [BYTE_W-1:0] st_b0;
    logic [CNT_W-1:0]  level_nx;

    // Next slot index with wrap at DEPTH.
    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    // Decide where the popped byte comes from and what gets stored.
    always_comb begin
        has_old  = (level != '0);
        bypass   = pop_req && !has_old && (push_n != 2'd0);
        pop_ok   = pop_req && (has_old || (push_n != 2'd0));
        pop_old  = pop_ok && has_old;
        pop_byte = has_old ? slots[head] : push_lo;
        st_n     = bypass ? (push_n - 2'd1) : push_n;
        st_b0    = bypass ? push_hi : push_lo;
        tail_p1  = nxt(tail);
        tail_p2  = nxt(tail_p1);
        level_nx = level + {{(CNT_W-2){1'b0}}, st_n}
                         - {{(CNT_W-1){1'b0}}, pop_old};
    end

    // Per-slot write port: first stored byte at tail, second at tail+1.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic we0;
        logic we1;
        assign we0 = (st_n != 2'd0) && (tail == IDX_W'(g));
        assign we1 = (st_n == 2'd2) && (tail_p1 == IDX_W'(g));
        // Capture the byte assigned to this slot.
        always_ff @(posedge clk) begin
            if (we0) begin
                slots[g] <= st_b0;
            end else if (we1) begin
                slots[g] <= push_hi;
            end
        end
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head  <= '0;
            tail  <= '0;
            level <= '0;
        end else begin
            if (pop_old) begin
                head <= nxt(head);
            end
            case (st_n)
                2'd1:    tail <= tail_p1;
                2'd2:    tail <= tail_p2;
                default: tail <= tail;
            endcase
            level <= level_nx;
        end
    end

    // R3: the fill level never passes the capacity.
    p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    // R3: the producer never offers more bytes than the free slots.
    p_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(level) + 32'(push_n)) <= DEPTH);

    // R5: a clear leaves the ring empty on the next cycle.
    p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level == '0));

endmodule

// File: rtl/pfq_fetch.sv
// Fetch pointer and bus request generation.
// Requests a word at an even pointer, a single upper-lane byte at an
// odd pointer, and only while enough slots are free. A redirect
// reloads the pointer and suppresses the request, which cancels a
// fetch waiting for its acknowledge.
module pfq_fetch #(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 'h0100,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                redirect,
    input  logic [ADDR_W-1:0]   redirect_addr,
    input  logic [CNT_W-1:0]    level,
    output logic                bus_req,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_single,
    input  logic                bus_ack,
    input  logic [2*BYTE_W-1:0] bus_data,
    output logic [1:0]          push_n,
    output logic [BYTE_W-1:0]   push_lo,
    output logic [BYTE_W-1:0]   push_hi
);

    logic [ADDR_W-1:0] ptr;
    logic [1:0]        need;
    logic [CNT_W-1:0]  free;
    logic              done;

    // Request sizing, room test and lane steering.
    always_comb begin
        need       = ptr[0] ? 2'd1 : 2'd2;
        free       = CNT_W'(DEPTH) - level;
        bus_req    = !redirect && (free >= {{(CNT_W-2){1'b0}}, need});
        done       = bus_req && bus_ack;
        push_n     = done ? need : 2'd0;
        push_lo    = ptr[0] ? bus_data[2*BYTE_W-1:BYTE_W] : bus_data[BYTE_W-1:0];
        push_hi    = bus_data[2*BYTE_W-1:BYTE_W];
        bus_addr   = ptr;
        bus_single = ptr[0];
    end

    // Fetch pointer: reset address, redirect target, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= RESET_ADDR;
        end else if (redirect) begin
            ptr <= redirect_addr;
        end else if (done) begin
            ptr <= ptr + ADDR_W'(need);
        end
    end

    // R12: a completed fetch moves the pointer by the bytes fetched.
    p_ptr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ptr == $past(ptr) + ADDR_W'($past(need))));

    // R5: a redirect loads the target address.
    p_redirect_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (ptr == $past(redirect_addr)));

    // R4: an odd pointer is always followed by an even one after a fetch.
    p_odd_realign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ptr[0]) |=> !ptr[0]);

endmodule

// File: rtl/pfq_status.sv
// Registered queue status code describing the last edge's operation.
// Assumes a redirect outranks a byte taken in the same cycle.
module pfq_status
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       redirect,
    input  logic       took,
    input  logic       took_first,
    output logic [1:0] q_status
);

    qstat_e code;

    // Encode the operation committed at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= QS_IDLE;
        end else if (redirect) begin
            code <= QS_FLUSH;
        end else if (took) begin
            code <= took_first ? QS_FIRST : QS_NEXT;
        end else begin
            code <= QS_IDLE;
        end
    end

    assign q_status = code;

endmodule

// File: rtl/ibyte_prefetch_queue.sv
// Top of the instruction byte prefetch queue: a fetch pointer that
// keeps a six-byte store topped up from a 16-bit bus, a byte read port
// for the execution unit with empty-store forwarding, and a status
// code. Assumes fetch_data is valid in the cycle fetch_ack is high.
module ibyte_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH  = 6,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 'h0100,
    localparam int unsigned WORD_W = 2 * BYTE_W,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_single,
    input  logic              fetch_ack,
    input  logic [WORD_W-1:0] fetch_data,
    input  logic              rd_req,
    input  logic              rd_first,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    output logic [1:0]        q_status
);

    logic [CNT_W-1:0]  level;
    logic [1:0]        push_n;
    logic [BYTE_W-1:0] push_lo;
    logic [BYTE_W-1:0] push_hi;
    logic              pop_req;

    // A redirect blocks the read port for its cycle.
    assign pop_req = rd_req && !redirect;

    pfq_fetch #(
        .DEPTH      (DEPTH),
        .BYTE_W     (BYTE_W),
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .level         (level),
        .bus_req       (fetch_req),
        .bus_addr      (fetch_addr),
        .bus_single    (fetch_single),
        .bus_ack       (fetch_ack),
        .bus_data      (fetch_data),
        .push_n        (push_n),
        .push_lo       (push_lo),
        .push_hi       (push_hi)
    );

    pfq_ring #(
        .DEPTH  (DEPTH),
        .BYTE_W (BYTE_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (redirect),
        .push_n   (push_n),
        .push_lo  (push_lo),
        .push_hi  (push_hi),
        .pop_req  (pop_req),
        .pop_ok   (rd_valid),
        .pop_byte (rd_byte),
        .level    (level)
    );

    pfq_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .redirect   (redirect),
        .took       (rd_valid),
        .took_first (rd_first),
        .q_status   (q_status)
    );

    // R6: a read on an empty store with no fetch completing stalls.
    p_stall_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (level == '0) && !(fetch_req && fetch_ack)) |-> !rd_valid);

    // R3: no word request unless two slots are free.
    p_word_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_single) |-> (32'(level) + 2 <= DEPTH));

    // R9: an opening byte taken is reported as 01.
    p_stat_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_first) |=> (q_status == QS_FIRST));

    // R10: a later byte taken is reported as 11.
    p_stat_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_first) |=> (q_status == QS_NEXT));

    // R11: a redirect is reported as 10 and blocks the read port.
    p_stat_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (q_status == QS_FLUSH));

    // R8: with no read and no redirect the status returns to 00.
    p_stat_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !redirect) |=> (q_status == QS_IDLE));

endmodule

// File: tb/sim_ibyte_prefetch_queue.sv
module sim_ibyte_prefetch_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic        fetch_single;
    logic        fetch_ack = 1'b0;
    logic [15:0] fetch_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_first = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_byte;
    logic        redirect = 1'b0;
    logic [15:0] redirect_addr = '0;
    logic [1:0]  q_status;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ibyte_prefetch_queue #(.RESET_ADDR(16'h0100)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_single(fetch_single), .fetch_ack(fetch_ack),
        .fetch_data(fetch_data), .rd_req(rd_req), .rd_first(rd_first),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .redirect(redirect),
        .redirect_addr(redirect_addr), .q_status(q_status)
    );

    typedef struct packed {
        logic        rd;
        logic        first;
        logic        fl;
        logic [15:0] fa;
        logic        ack;
        logic [15:0] dat;
        logic        x_req;
        logic [15:0] x_addr;
        logic        x_single;
        logic        x_valid;
        logic [7:0]  x_byte;
        logic [1:0]  x_stat;
    } vec_t;

    // rd first fl fa ack dat | req addr single valid byte status
    localparam vec_t TBL [13] = '{
        '{1'b0,1'b0,1'b0,16'h0000,1'b0,16'h0000, 1'b1,16'h0100,1'b0,1'b0,8'h00,2'b00}, // idle, R8
        '{1'b0,1'b0,1'b0,16'h0000,1'b1,16'hB2A1, 1'b1,16'h0100,1'b0,1'b0,8'h00,2'b00}, // first word
        '{1'b1,1'b1,1'b0,16'h0000,1'b1,16'hD4C3, 1'b1,16'h0102,1'b0,1'b1,8'hA1,2'b01}, // R9 low lane first
        '{1'b1,1'b0,1'b0,16'h0000,1'b1,16'hF6E5, 1'b1,16'h0104,1'b0,1'b1,8'hB2,2'b11}, // R10
        '{1'b0,1'b0,1'b0,16'h0000,1'b1,16'h1807, 1'b1,16'h0106,1'b0,1'b0,8'h00,2'b00}, // fills to six
        '{1'b0,1'b0,1'b0,16'h0000,1'b1,16'h9999, 1'b0,16'h0108,1'b0,1'b0,8'h00,2'b00}, // R3 full, ack ignored
        '{1'b1,1'b1,1'b0,16'h0000,1'b0,16'h0000, 1'b0,16'h0108,1'b0,1'b1,8'hC3,2'b01}, // R3 room counted before pop
        '{1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000, 1'b0,16'h0108,1'b0,1'b1,8'hD4,2'b11}, // R3 one free, no word
        '{1'b1,1'b0,1'b1,16'h0203,1'b1,16'h7777, 1'b0,16'h0108,1'b0,1'b0,8'h00,2'b10}, // R5 R11 redirect wins
        '{1'b1,1'b1,1'b0,16'h0000,1'b1,16'h5A00, 1'b1,16'h0203,1'b1,1'b1,8'h5A,2'b01}, // R4 R7 odd, upper lane
        '{1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000, 1'b1,16'h0204,1'b0,1'b0,8'h00,2'b00}, // R6 stall, realigned
        '{1'b1,1'b0,1'b0,16'h0000,1'b1,16'h3C2B, 1'b1,16'h0204,1'b0,1'b1,8'h2B,2'b11}, // R7 forward
        '{1'b1,1'b0,1'b0,16'h0000,1'b0,16'h0000, 1'b1,16'h0206,1'b0,1'b1,8'h3C,2'b11}  // R7 remainder kept
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string stat_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R8";
            2'b01:   return "R9";
            2'b11:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic drive(input logic rd, input logic first, input logic fl,
                         input logic [15:0] fa, input logic ack,
                         input logic [15:0] dat);
        @(negedge clk);
        rd_req = rd; rd_first = first; redirect = fl;
        redirect_addr = fa; fetch_ack = ack; fetch_data = dat;
        #2;
    endtask

    task automatic edge_done();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "q_status after reset", 32'(q_status), 32'h0);
        chk("R1", "fetch_addr after reset", 32'(fetch_addr), 32'h0100);

        foreach (TBL[i]) begin
            drive(TBL[i].rd, TBL[i].first, TBL[i].fl, TBL[i].fa, TBL[i].ack, TBL[i].dat);
            chk("R3", $sformatf("v%0d fetch_req", i), 32'(fetch_req), 32'(TBL[i].x_req));
            chk("R12", $sformatf("v%0d fetch_addr", i), 32'(fetch_addr), 32'(TBL[i].x_addr));
            chk("R4", $sformatf("v%0d fetch_single", i), 32'(fetch_single), 32'(TBL[i].x_single));
            chk("R6", $sformatf("v%0d rd_valid", i), 32'(rd_valid), 32'(TBL[i].x_valid));
            if (TBL[i].x_valid)
                chk("R2", $sformatf("v%0d rd_byte", i), 32'(rd_byte), 32'(TBL[i].x_byte));
            edge_done();
            chk(stat_tag(TBL[i].x_stat), $sformatf("v%0d q_status", i),
                32'(q_status), 32'(TBL[i].x_stat));
        end

        // R7: forwarding into an empty store, remainder kept.
        drive(1, 1, 0, 16'h0, 1, 16'h4433);
        chk("R7", "forward valid", 32'(rd_valid), 32'h1);
        chk("R7", "forward byte", 32'(rd_byte), 32'h33);
        edge_done();
        chk("R9", "status after forward", 32'(q_status), 32'h1);
        drive(1, 0, 0, 16'h0, 0, 16'h0);
        chk("R7", "remainder byte", 32'(rd_byte), 32'h44);
        edge_done();
        chk("R10", "status later byte", 32'(q_status), 32'h3);

        // R5: redirect cancels a pending fetch and reloads the pointer.
        drive(0, 0, 1, 16'hFFFE, 1, 16'h5555);
        chk("R5", "fetch_req during redirect", 32'(fetch_req), 32'h0);
        edge_done();
        chk("R11", "status after redirect", 32'(q_status), 32'h2);
        drive(1, 1, 0, 16'h0, 0, 16'h0);
        chk("R5", "fetch_addr after redirect", 32'(fetch_addr), 32'hFFFE);
        chk("R5", "store empty after redirect", 32'(rd_valid), 32'h0);
        edge_done();
        chk("R8", "status after stall", 32'(q_status), 32'h0);

        // R12: wrap at the top of the address space.
        drive(0, 0, 0, 16'h0, 1, 16'h2211);
        chk("R12", "request at FFFE", 32'(fetch_req), 32'h1);
        edge_done();
        drive(1, 1, 0, 16'h0, 0, 16'h0);
        chk("R12", "wrapped fetch_addr", 32'(fetch_addr), 32'h0000);
        chk("R2", "low lane first", 32'(rd_byte), 32'h11);
        edge_done();
        drive(1, 0, 0, 16'h0, 0, 16'h0);
        chk("R2", "high lane second", 32'(rd_byte), 32'h22);
        edge_done();

        // R3: fill to six, further acks ignored, then drain in order.
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 0, 16'h0, 1, {8'(2*k+2), 8'(2*k+1)});
            if (k == 3) chk("R3", "no request when full", 32'(fetch_req), 32'h0);
            edge_done();
        end
        for (int k = 0; k < 6; k++) begin
            drive(1, (k == 0), 0, 16'h0, 0, 16'h0);
            chk("R2", $sformatf("drain %0d valid", k), 32'(rd_valid), 32'h1);
            chk("R2", $sformatf("drain %0d byte", k), 32'(rd_byte), 32'(k + 1));
            edge_done();
        end
        drive(1, 0, 0, 16'h0, 0, 16'h0);
        chk("R6", "stall after drain", 32'(rd_valid), 32'h0);
        edge_done();

        // R1: reset clears a partly filled store.
        drive(0, 0, 0, 16'h0, 1, 16'h9988);
        edge_done();
        @(negedge clk);
        rst_n = 1'b0; fetch_ack = 1'b0;
        repeat (2) @(posedge clk);
        drive(1, 1, 0, 16'h0, 0, 16'h0);
        rst_n = 1'b1;
        #1;
        chk("R1", "store empty after reset", 32'(rd_valid), 32'h0);
        chk("R1", "fetch_addr after reset", 32'(fetch_addr), 32'h0100);
        chk("R1", "fetch_req after reset", 32'(fetch_req), 32'h1);
        chk("R1", "q_status after reset", 32'(q_status), 32'h0);
        edge_done();

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule